// File: doc/BRIEF.md
# JTAG Chain Scan Engine

This block runs a single instruction-register or data-register scan on one device that sits in a daisy chain of several test-access-port devices. The other devices in the chain are covered by padding: a configurable run of bits shifted ahead of the target bits (the lead pad) and a run shifted after them (the trail pad). Each kind of scan has its own pad lengths. The pad contents either come from the pad-bit inputs or are all ones.

The engine keeps track of where it left the TAP controller. It drives TCK, TMS and TDI itself. It walks the TAP into the correct shift state using a fixed entry sequence, shifts the whole padded frame LSB first, and parks in the pause state of the same branch. It can then walk on to a programmed stop state. When capture is requested, it samples TDO on every shift clock and returns only the bits that line up with the target. The TAP state is unknown after reset, so the first command also drives a reset-and-idle prefix.

A command is taken in any cycle where `cmd_valid` is high and `busy` is low. One system clock makes each TCK half period.

Top module: `jscan_engine`

## Requirements
- R1: While reset is high, and after it until a command arrives, busy, done, tck, tms, tdi and tgt_out are all 0.
- R2: The frame shifted on TDI is the lead pad, then the target, then the trail pad, each LSB first. Its length is lead length + cmd_len + trail length. The IR lead/trail lengths are used when cmd_ir=1 and the DR lengths when cmd_ir=0.
- R3: The TMS bits that enter the shift state (listed in time order) are as follows:
  - DR from the idle class: 1,0,0. DR from a pause class: 1,1,1,0,0.
  - IR from the idle class: 1,1,0,0. IR from a pause class: 1,1,1,1,0,0.
  - When the position is unknown (first command after reset), the prefix 1,1,1,1,1,0 comes first.
  - When the position is test-logic-reset, a single 0 comes first.
- R4: TMS is 0 on every shift clock except the last, where it is 1. One further clock with TMS=0 leaves the TAP in the pause state of the scanned branch.
- R5: The stop code (ir_stop for IR scans, dr_stop for DR scans) selects the end state:
  - 0 or 3: stay in pause.
  - 1: run-test/idle, reached with TMS 1,1,0.
  - 2: test-logic-reset, reached with TMS 1,1,1,1,1.
- R6: With cmd_capture=1, tgt_out bit i equals the TDO value sampled on shift clock number (lead length + i), for i < cmd_len. Bits at or above cmd_len are 0. With cmd_capture=0, tgt_out keeps its previous value.
- R7: With pad_explicit=0, every pad bit shifted is 1. With pad_explicit=1, pad bit i comes from pre_bits[i] or post_bits[i].
- R8: TDI is 0 on every TCK rising edge that is not a shift clock. While idle, TMS and TDI are 0.
- R9: While busy, TCK toggles on every system clock. TMS and TDI hold while TCK is high. TDO is sampled at the TCK rising edge.
- R10: done is a one-cycle pulse in the first cycle with busy low after a scan. A command offered while busy is ignored.
- R11: A scan issues exactly entry length + frame length + 1 + stop-walk length TCK rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offer |
| cmd_ir | input | 1 | 1 = instruction scan, 0 = data scan |
| cmd_len | input | 5 | Target bit count, 1 to TGT_W |
| cmd_capture | input | 1 | Return the target's TDO bits |
| tgt_in | input | 16 | Target bits to shift, bit 0 first |
| ir_pre_len | input | 4 | IR lead pad length |
| ir_post_len | input | 4 | IR trail pad length |
| dr_pre_len | input | 4 | DR lead pad length |
| dr_post_len | input | 4 | DR trail pad length |
| pre_bits | input | 8 | Lead pad contents |
| post_bits | input | 8 | Trail pad contents |
| pad_explicit | input | 1 | 1 = use pad inputs, 0 = pads all ones |
| ir_stop | input | 2 | End state code after IR scans |
| dr_stop | input | 2 | End state code after DR scans |
| tdo | input | 1 | Chain serial output |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Chain serial input |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Scan-finished pulse |
| tgt_out | output | 16 | Captured target bits |

## Verification
Two things can meet on the same clock edge. The first is a new command offered while a scan is still running. The second is the engine's own sequencing: the edge that ends the stop walk also latches the captured target and updates the remembered TAP position. The bench offers a conflicting command (opposite register kind) in the middle of some scans. It then judges the outcome from a modelled TAP and a modelled chain: the rising-edge count, the chain contents and the end state must all match the original command alone. After the done pulse, the bench also checks that busy stays low. Because each scan starts from where the previous one ended, a sweep of pad lengths, stop codes and register kinds covers every entry class.

// File: rtl/jscan_pkg.sv
package jscan_pkg;

    localparam int SEQ_W  = 16;
    localparam int SEQ_IW = $clog2(SEQ_W);

    // Stop-state selector codes
    localparam logic [1:0] STOP_IDLE = 2'd1;
    localparam logic [1:0] STOP_RST  = 2'd2;

    typedef enum logic [2:0] {
        POS_UNK, POS_RST, POS_IDLE, POS_DRP, POS_IRP
    } tap_pos_e;

    typedef enum logic [1:0] {
        PH_WAIT, PH_HEAD, PH_SHIFT, PH_TAIL
    } phase_e;

    // TMS program: bits emitted LSB first, n = number of clocks
    typedef struct packed {
        logic [SEQ_W-1:0] bits;
        logic [4:0]       n;
    } tms_prog_t;

    function automatic tms_prog_t prog_add(tms_prog_t p, logic [SEQ_W-1:0] b, int k);
        tms_prog_t r;
        r.bits = p.bits | (b << p.n);
        r.n    = p.n + 5'(k);
        return r;
    endfunction

    function automatic tms_prog_t head_prog(tap_pos_e pos, logic ir);
        tms_prog_t p;
        p = '0;
        if (pos == POS_UNK) p = prog_add(p, 16'b011111, 6);
        if (pos == POS_RST) p = prog_add(p, 16'b0, 1);
        if (pos == POS_DRP || pos == POS_IRP)
            p = ir ? prog_add(p, 16'b001111, 6) : prog_add(p, 16'b00111, 5);
        else
            p = ir ? prog_add(p, 16'b0011, 4) : prog_add(p, 16'b001, 3);
        return p;
    endfunction

    function automatic tms_prog_t tail_prog(logic [1:0] stop);
        tms_prog_t p;
        p = prog_add('0, 16'b0, 1);
        if (stop == STOP_IDLE) p = prog_add(p, 16'b011, 3);
        if (stop == STOP_RST)  p = prog_add(p, 16'b11111, 5);
        return p;
    endfunction

    function automatic tap_pos_e end_pos(logic ir, logic [1:0] stop);
        if (stop == STOP_IDLE) return POS_IDLE;
        if (stop == STOP_RST)  return POS_RST;
        return ir ? POS_IRP : POS_DRP;
    endfunction

endpackage

// File: rtl/jscan_frame.sv
module jscan_frame #(
    parameter int PAD_W = 8,
    parameter int TGT_W = 16,
    parameter int PL_W  = 4,
    parameter int TL_W  = 5,
    parameter int IDX_W = 6
) (
    input  logic [PL_W-1:0]          pre_len,
    input  logic [PL_W-1:0]          post_len,
    input  logic [TL_W-1:0]          tgt_len,
    input  logic [PAD_W-1:0]         pre_bits,
    input  logic [PAD_W-1:0]         post_bits,
    input  logic [TGT_W-1:0]         tgt_bits,
    input  logic                     explicit_pad,
    output logic [2*PAD_W+TGT_W-1:0] frame
);
    localparam int TOT = 2*PAD_W + TGT_W;
    localparam logic [TOT-1:0] ALL1 = '1;

    logic [TOT-1:0] pre_m, tgt_m, post_m;
    logic [IDX_W-1:0] post_at;

    always_comb begin
        pre_m   = (explicit_pad ? TOT'(pre_bits)  : ALL1) & ~(ALL1 << pre_len);
        post_m  = (explicit_pad ? TOT'(post_bits) : ALL1) & ~(ALL1 << post_len);
        tgt_m   = TOT'(tgt_bits) & ~(ALL1 << tgt_len);
        post_at = IDX_W'(pre_len) + IDX_W'(tgt_len);
        frame   = pre_m | (tgt_m << pre_len) | (post_m << post_at);
    end
endmodule

// File: rtl/jscan_extract.sv
module jscan_extract #(
    parameter int PAD_W = 8,
    parameter int TGT_W = 16,
    parameter int PL_W  = 4,
    parameter int TL_W  = 5
) (
    input  logic [2*PAD_W+TGT_W-1:0] cap,
    input  logic [PL_W-1:0]          pre_len,
    input  logic [TL_W-1:0]          tgt_len,
    output logic [TGT_W-1:0]         tgt
);
    localparam logic [TGT_W-1:0] ONES = '1;

    always_comb tgt = TGT_W'(cap >> pre_len) & ~(ONES << tgt_len);
endmodule

// File: rtl/jscan_engine.sv
module jscan_engine
    import jscan_pkg::*;
#(
    parameter int PAD_W = 8,
    parameter int TGT_W = 16,
    localparam int PL_W = $clog2(PAD_W+1),
    localparam int TL_W = $clog2(TGT_W+1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic             cmd_ir,
    input  logic [TL_W-1:0]  cmd_len,
    input  logic             cmd_capture,
    input  logic [TGT_W-1:0] tgt_in,
    input  logic [PL_W-1:0]  ir_pre_len,
    input  logic [PL_W-1:0]  ir_post_len,
    input  logic [PL_W-1:0]  dr_pre_len,
    input  logic [PL_W-1:0]  dr_post_len,
    input  logic [PAD_W-1:0] pre_bits,
    input  logic [PAD_W-1:0] post_bits,
    input  logic             pad_explicit,
    input  logic [1:0]       ir_stop,
    input  logic [1:0]       dr_stop,
    input  logic             tdo,
    output logic             tck,
    output logic             tms,
    output logic             tdi,
    output logic             busy,
    output logic             done,
    output logic [TGT_W-1:0] tgt_out
);
    localparam int TOT   = 2*PAD_W + TGT_W;
    localparam int FI_W  = $clog2(TOT);
    localparam int IDX_W = FI_W + 1;

    phase_e           ph;
    tap_pos_e         pos;
    tms_prog_t        head_q, tail_q;
    logic [IDX_W-1:0] idx, tot_q, last_idx;
    logic [TOT-1:0]   frame_q, cap_q, frame_d;
    logic             ir_q, capen_q;
    logic [1:0]       stop_q;
    logic [PL_W-1:0]  pre_sel, post_sel, pre_q;
    logic [TL_W-1:0]  len_q;
    logic [TGT_W-1:0] tgt_x;

    assign pre_sel  = cmd_ir ? ir_pre_len  : dr_pre_len;
    assign post_sel = cmd_ir ? ir_post_len : dr_post_len;

    jscan_frame #(.PAD_W(PAD_W), .TGT_W(TGT_W), .PL_W(PL_W), .TL_W(TL_W), .IDX_W(IDX_W)) u_frame (
        .pre_len(pre_sel), .post_len(post_sel), .tgt_len(cmd_len),
        .pre_bits(pre_bits), .post_bits(post_bits), .tgt_bits(tgt_in),
        .explicit_pad(pad_explicit), .frame(frame_d)
    );

    jscan_extract #(.PAD_W(PAD_W), .TGT_W(TGT_W), .PL_W(PL_W), .TL_W(TL_W)) u_extract (
        .cap(cap_q), .pre_len(pre_q), .tgt_len(len_q), .tgt(tgt_x)
    );

    always_comb begin
        case (ph)
            PH_HEAD:  last_idx = IDX_W'(head_q.n) - 1'b1;
            PH_SHIFT: last_idx = tot_q - 1'b1;
            default:  last_idx = IDX_W'(tail_q.n) - 1'b1;
        endcase
    end

    always_comb begin
        tms = 1'b0;
        tdi = 1'b0;
        case (ph)
            PH_HEAD:  tms = head_q.bits[idx[SEQ_IW-1:0]];
            PH_SHIFT: begin
                tms = (idx == tot_q - 1'b1);
                tdi = frame_q[idx[FI_W-1:0]];
            end
            PH_TAIL:  tms = tail_q.bits[idx[SEQ_IW-1:0]];
            default:  ;
        endcase
    end

    assign busy = (ph != PH_WAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= PH_WAIT;
            pos     <= POS_UNK;
            tck     <= 1'b0;
            idx     <= '0;
            done    <= 1'b0;
            tgt_out <= '0;
            cap_q   <= '0;
            frame_q <= '0;
            head_q  <= '0;
            tail_q  <= '0;
            tot_q   <= '0;
            ir_q    <= 1'b0;
            capen_q <= 1'b0;
            stop_q  <= '0;
            pre_q   <= '0;
            len_q   <= '0;
        end else begin
            done <= 1'b0;
            if (ph == PH_WAIT) begin
                if (cmd_valid) begin
                    ph      <= PH_HEAD;
                    idx     <= '0;
                    tck     <= 1'b0;
                    ir_q    <= cmd_ir;
                    capen_q <= cmd_capture;
                    stop_q  <= cmd_ir ? ir_stop : dr_stop;
                    head_q  <= head_prog(pos, cmd_ir);
                    tail_q  <= tail_prog(cmd_ir ? ir_stop : dr_stop);
                    frame_q <= frame_d;
                    pre_q   <= pre_sel;
                    len_q   <= cmd_len;
                    tot_q   <= IDX_W'(pre_sel) + IDX_W'(cmd_len) + IDX_W'(post_sel);
                end
            end else if (!tck) begin
                tck <= 1'b1;
                if (ph == PH_SHIFT && capen_q) cap_q[idx[FI_W-1:0]] <= tdo;
            end else begin
                tck <= 1'b0;
                if (idx == last_idx) begin
                    idx <= '0;
                    case (ph)
                        PH_HEAD:  ph <= PH_SHIFT;
                        PH_SHIFT: ph <= PH_TAIL;
                        default: begin
                            ph   <= PH_WAIT;
                            done <= 1'b1;
                            pos  <= end_pos(ir_q, stop_q);
                            if (capen_q) tgt_out <= tgt_x;
                        end
                    endcase
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/jscan_engine_chk.sv
module jscan_engine_chk (
    input logic clk,
    input logic rst,
    input logic tck,
    input logic tms,
    input logic tdi,
    input logic busy,
    input logic done
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!tck && !tms && !tdi));

    assert_pins_hold_high_R9: assert property (@(posedge clk) disable iff (rst)
        tck |-> ($stable(tms) && $stable(tdi)));

    assert_tck_toggles_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (tck != $past(tck)));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_after_busy_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));
endmodule

bind jscan_engine jscan_engine_chk u_chk (
    .clk(clk), .rst(rst), .tck(tck), .tms(tms), .tdi(tdi), .busy(busy), .done(done)
);

// File: tb/jscan_engine_bench.sv
module jscan_engine_bench;
    localparam int S_RST = 0, S_IDLE = 1, S_DSEL = 2, S_DCAP = 3, S_DSH = 4,
                   S_DX1 = 5, S_DP = 6, S_DX2 = 7, S_DUP = 8, S_ISEL = 9,
                   S_ICAP = 10, S_ISH = 11, S_IX1 = 12, S_IP = 13, S_IX2 = 14, S_IUP = 15;

    logic clk = 1'b0, rst = 1'b1;
    logic cmd_valid = 0, cmd_ir = 0, cmd_capture = 0, pad_explicit = 0;
    logic [4:0] cmd_len = 5'd1;
    logic [15:0] tgt_in = '0;
    logic [3:0] ir_pre_len = 0, ir_post_len = 0, dr_pre_len = 0, dr_post_len = 0;
    logic [7:0] pre_bits = '0, post_bits = '0;
    logic [1:0] ir_stop = 0, dr_stop = 0;
    logic tdo, tck, tms, tdi, busy, done;
    logic [15:0] tgt_out;

    int checks = 0, errors = 0;
    int tap = S_IP;
    int edge_cnt, viol, first_sh, sh_ir, chain_len;
    logic [31:0] drc = '0, irc = '0;
    logic [31:0] seed = 32'h1234_5678;
    int epos = 0;          // 0 unknown, 1 reset, 2 idle, 3 dr pause, 4 ir pause
    logic [15:0] last_tgt = '0;

    always #4 clk = ~clk;

    jscan_engine u_jscan_engine (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ir(cmd_ir), .cmd_len(cmd_len),
        .cmd_capture(cmd_capture), .tgt_in(tgt_in), .ir_pre_len(ir_pre_len),
        .ir_post_len(ir_post_len), .dr_pre_len(dr_pre_len), .dr_post_len(dr_post_len),
        .pre_bits(pre_bits), .post_bits(post_bits), .pad_explicit(pad_explicit),
        .ir_stop(ir_stop), .dr_stop(dr_stop), .tdo(tdo), .tck(tck), .tms(tms), .tdi(tdi),
        .busy(busy), .done(done), .tgt_out(tgt_out)
    );

    function automatic int tap_step(int s, logic m);
        case (s)
            S_RST:  return m ? S_RST  : S_IDLE;
            S_IDLE: return m ? S_DSEL : S_IDLE;
            S_DSEL: return m ? S_ISEL : S_DCAP;
            S_DCAP: return m ? S_DX1  : S_DSH;
            S_DSH:  return m ? S_DX1  : S_DSH;
            S_DX1:  return m ? S_DUP  : S_DP;
            S_DP:   return m ? S_DX2  : S_DP;
            S_DX2:  return m ? S_DUP  : S_DSH;
            S_DUP:  return m ? S_DSEL : S_IDLE;
            S_ISEL: return m ? S_RST  : S_ICAP;
            S_ICAP: return m ? S_IX1  : S_ISH;
            S_ISH:  return m ? S_IX1  : S_ISH;
            S_IX1:  return m ? S_IUP  : S_IP;
            S_IP:   return m ? S_IX2  : S_IP;
            S_IX2:  return m ? S_IUP  : S_ISH;
            default: return m ? S_DSEL : S_IDLE;
        endcase
    endfunction

    assign tdo = (tap == S_ISH) ? irc[0] : drc[0];

    always @(posedge tck) begin
        int nx;
        edge_cnt++;
        if (tdi && tap != S_DSH && tap != S_ISH) viol++;
        if (tap == S_DSH) begin drc = drc >> 1; drc[chain_len-1] = tdi; end
        if (tap == S_ISH) begin irc = irc >> 1; irc[chain_len-1] = tdi; end
        nx = tap_step(tap, tms);
        if (first_sh < 0 && (nx == S_DSH || nx == S_ISH)) begin
            first_sh = edge_cnt;
            sh_ir = (nx == S_ISH) ? 1 : 0;
        end
        tap = nx;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] nxt_rand();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed;
    endfunction

    task automatic do_scan(input bit ir, input int len, input int pre, input int post,
                           input bit capt, input int stop, input bit expl, input bit poke);
        int L, head, tail, end_tap, wd;
        logic [31:0] pat, exp_frame, chain_now;
        logic [15:0] tgt, exp_tgt;
        logic [7:0] pb, qb;
        L = pre + len + post;
        tgt = 16'(nxt_rand());
        pb  = 8'(nxt_rand());
        qb  = 8'(nxt_rand());
        pat = nxt_rand();
        if (L < 32) pat = pat & ((32'd1 << L) - 1);
        // expected frame on TDI
        exp_frame = '0;
        for (int i = 0; i < L; i++) begin
            if (i < pre)            exp_frame[i] = expl ? pb[i] : 1'b1;
            else if (i < pre + len) exp_frame[i] = tgt[i-pre];
            else                    exp_frame[i] = expl ? qb[i-pre-len] : 1'b1;
        end
        exp_tgt = capt ? 16'(pat >> pre) : last_tgt;
        if (capt && len < 16) exp_tgt = exp_tgt & ((16'd1 << len) - 1);
        head = (epos == 0) ? 6 : (epos == 1) ? 1 : 0;
        head += (epos >= 3) ? (ir ? 6 : 5) : (ir ? 4 : 3);
        tail = 1 + ((stop == 1) ? 3 : (stop == 2) ? 5 : 0);
        end_tap = (stop == 1) ? S_IDLE : (stop == 2) ? S_RST : (ir ? S_IP : S_DP);

        @(negedge clk);
        chain_len = L;
        if (ir) irc = pat; else drc = pat;
        edge_cnt = 0; viol = 0; first_sh = -1; sh_ir = -1;
        cmd_ir = ir; cmd_len = 5'(len); cmd_capture = capt; tgt_in = tgt;
        if (ir) begin ir_pre_len = 4'(pre); ir_post_len = 4'(post); ir_stop = 2'(stop);
                      dr_pre_len = 4'(post); dr_post_len = 4'(pre); dr_stop = 2'(3 - stop); end
        else    begin dr_pre_len = 4'(pre); dr_post_len = 4'(post); dr_stop = 2'(stop);
                      ir_pre_len = 4'(post); ir_post_len = 4'(pre); ir_stop = 2'(3 - stop); end
        pre_bits = pb; post_bits = qb; pad_explicit = expl;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(busy == 1'b1, "R10", "busy after accept", busy, 1);
        if (poke) begin
            repeat (7) @(negedge clk);
            cmd_valid = 1'b1; cmd_ir = ~ir; cmd_len = 5'd3;
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        wd = 0;
        while (!done && wd < 2000) begin @(negedge clk); wd++; end
        check(done == 1'b1, "R10", "done seen", done, 1);
        check(busy == 1'b0, "R10", "busy low at done", busy, 0);
        chain_now = ir ? irc : drc;
        check(edge_cnt == head + L + tail, "R11", "tck rising edges", edge_cnt, head + L + tail);
        check(first_sh == head, "R3", "edges before shift", first_sh, head);
        check(sh_ir == int'(ir), "R3", "shift branch", sh_ir, ir);
        if (expl)
            check(chain_now == exp_frame, "R2", "chain contents", chain_now, exp_frame);
        else
            check(chain_now == exp_frame, "R7", "ones padding", chain_now, exp_frame);
        if (stop == 0 || stop == 3)
            check(tap == end_tap, "R4", "parked pause state", tap, end_tap);
        else
            check(tap == end_tap, "R5", "stop state", tap, end_tap);
        check(viol == 0, "R8", "tdi high off shift", viol, 0);
        check(tgt_out == exp_tgt, "R6", "target out", tgt_out, exp_tgt);
        last_tgt = exp_tgt;
        epos = (stop == 1) ? 2 : (stop == 2) ? 1 : (ir ? 4 : 3);
        repeat (3) @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R10", "no restart", busy, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 100000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int k;
        int lens[3];
        lens[0] = 1; lens[1] = 5; lens[2] = 16;
        repeat (4) @(negedge clk);
        check(!busy && !done && !tck && !tms && !tdi, "R1", "outputs in reset",
              {busy, done, tck, tms, tdi}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(!busy && !tck && tgt_out == 16'd0, "R1", "idle after reset", tgt_out, 0);
        k = 0;
        for (int ir = 0; ir < 2; ir++)
            for (int pre = 0; pre < 4; pre++)
                for (int post = 0; post < 4; post++)
                    for (int li = 0; li < 3; li++) begin
                        do_scan(ir[0], lens[li], pre, post, (k % 3) != 0, k % 4,
                                k[0], (k % 5) == 0);
                        k++;
                    end
        do_scan(1'b0, 16, 8, 8, 1'b1, 0, 1'b1, 1'b0);
        do_scan(1'b1, 16, 8, 8, 1'b1, 2, 1'b0, 1'b1);
        do_scan(1'b1, 1, 8, 0, 1'b1, 1, 1'b1, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule